// File: doc/BRIEF.md
# Paired Forward-Stage Delay-Mode Controller

This block steers the recovery of two parallel pipeline stages whose results travel the same way and meet at a later adder stage, as the product branches of an FIR adder tree do. Each stage holds a double-sampled buffer. When the stage's comparison logic reports a mismatch, the stage enters delay mode. In delay mode its controller loads a spare buffer flop from the late-sampling flop and, one cycle later, routes that spare flop to the stage output.

The two stages must stay aligned, because the joining adder combines one word from each. Each stage controller therefore exports a stall flag while its own error is present, and it treats the partner's stall flag exactly like a local error. A mismatch in either stage therefore puts both stages through one delay-mode episode in the same cycles. Validity is carried active-low, with 0 meaning valid. The two stage validity outputs are combined with an OR, so the joining stage accepts data only when both branches delivered good words.

Top module: `fj_pair_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises with no error present, both stages drive select2 = 0, valid_n = 1 (invalid) and the joined valid join_valid_n = 1.
- R2: A stage's stall output is 1 in exactly the cycles in which that stage's own error input is 1, with no register delay.
- R3: In any cycle in which a stage's own error or its partner's stall is 1 (a trigger cycle), that stage drives select1 = 1 and enable = 1 in the same cycle; in all other cycles both are 0.
- R4: A stage drives select2 = 1 in the cycle directly after a trigger cycle and 0 otherwise.
- R5: A stage's valid_n is 1 in a trigger cycle; in any other cycle it equals that stage's upstream valid_n input as sampled at the previous clock edge.
- R6: join_valid_n is the OR of the two stage valid_n outputs in every cycle, so it is 0 (valid) only when both stages are valid.
- R7: An error on only one stage places both stages in delay mode in the same cycles, so that their select1, enable and select2 outputs are equal.
- R8: Errors on both stages in the same cycle produce a single delay-mode episode: select2 is 1 for one cycle only.
- R9: With both upstream inputs valid, a single one-cycle error on either stage makes join_valid_n 1 for exactly one cycle, and it is 0 before and after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_error | input | 1 | Mismatch flag of stage A's double-sampled buffer |
| a_up_valid_n | input | 1 | Active-low validity from stage A's upstream stage |
| b_error | input | 1 | Mismatch flag of stage B's double-sampled buffer |
| b_up_valid_n | input | 1 | Active-low validity from stage B's upstream stage |
| a_select1 | output | 1 | Stage A: spare flop takes the late-sampled data |
| a_select2 | output | 1 | Stage A: output taken from the spare flop |
| a_enable | output | 1 | Stage A: spare flop clock enable |
| a_valid_n | output | 1 | Stage A active-low output validity |
| a_stall | output | 1 | Stage A stall flag sent to stage B |
| b_select1 | output | 1 | Stage B: spare flop takes the late-sampled data |
| b_select2 | output | 1 | Stage B: output taken from the spare flop |
| b_enable | output | 1 | Stage B: spare flop clock enable |
| b_valid_n | output | 1 | Stage B active-low output validity |
| b_stall | output | 1 | Stage B stall flag sent to stage A |
| join_valid_n | output | 1 | Active-low validity seen by the joining stage |

## Verification
The two functions that can fall in the same cycle are a stage's own error and the stall arriving from its partner. Both errors may also arrive while the previous episode is still routing from the spare flop. The bench provokes these cases with directed cycles that raise both errors together and that raise errors back to back. It mixes these with random error and upstream-validity patterns drawn from a fixed seed. Each cycle is judged against a bench model that keeps its own record of the last trigger and the last upstream validity. This model expects one select2 cycle per trigger cycle, so coincident errors must not produce a double episode or a longer invalid window.

// File: rtl/fj_pkg.sv
`timescale 1ns/1ps
package fj_pkg;
  // Number of parallel stages meeting at the joining stage.
  localparam int unsigned FJ_BRANCHES = 2;

  // A stage enters delay mode on its own mismatch or its partner's stall.
  function automatic logic fj_trigger(input logic own_err, input logic partner_stall);
    return own_err | partner_stall;
  endfunction

  // Active-low validity of a stage output.
  function automatic logic fj_out_invalid(input logic trig, input logic up_invalid_q);
    return trig | up_invalid_q;
  endfunction
endpackage

// File: rtl/fj_stage_ctrl.sv
`timescale 1ns/1ps
module fj_stage_ctrl
  import fj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic error,
  input  logic valid_in1,
  input  logic valid_in2,
  input  logic stall_in,
  output logic select1,
  output logic select2,
  output logic enable,
  output logic valid_out,
  output logic stall_out
);
  logic trig;
  logic trig_q;
  logic up_inv_q;

  // Named event: this stage is in its capture cycle of delay mode.
  assign trig = fj_trigger(error, stall_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= 1'b0;
      up_inv_q <= 1'b1;
    end else begin
      trig_q   <= trig;
      up_inv_q <= valid_in1;
    end
  end

  assign stall_out = error;
  assign select1   = trig;
  assign enable    = trig;
  assign select2   = trig_q;
  assign valid_out = fj_out_invalid(trig, up_inv_q);

  // R7: in a capture cycle the partner's word is also marked invalid.
  a_r7_partner_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> valid_in2);

  // R4: a capture cycle is followed by routing from the spare flop.
  a_r4_route_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> select2);

  // R5: an invalid upstream word stays invalid one cycle later.
  a_r5_upstream_carried: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in1 |=> valid_out);
endmodule

// File: rtl/fj_valid_join.sv
`timescale 1ns/1ps
module fj_valid_join #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] branch_invalid,
  output logic         join_invalid
);
  logic [N:0] acc;
  assign acc[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign acc[i+1] = acc[i] | branch_invalid[i];
  end
  assign join_invalid = acc[N];
endmodule

// File: rtl/fj_pair_ctrl.sv
`timescale 1ns/1ps
module fj_pair_ctrl
  import fj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_error,
  input  logic a_up_valid_n,
  input  logic b_error,
  input  logic b_up_valid_n,
  output logic a_select1,
  output logic a_select2,
  output logic a_enable,
  output logic a_valid_n,
  output logic a_stall,
  output logic b_select1,
  output logic b_select2,
  output logic b_enable,
  output logic b_valid_n,
  output logic b_stall,
  output logic join_valid_n
);
  localparam int unsigned NB = FJ_BRANCHES;

  logic [NB-1:0] err_v, upv_v, sel1_v, sel2_v, en_v, vout_v, stall_v;

  assign err_v = {b_error, a_error};
  assign upv_v = {b_up_valid_n, a_up_valid_n};

  // Each branch takes its partner's stall and validity (cross-coupled).
  for (genvar i = 0; i < NB; i++) begin : g_stage
    localparam int unsigned P = (i + 1) % NB;
    fj_stage_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .error     (err_v[i]),
      .valid_in1 (upv_v[i]),
      .valid_in2 (vout_v[P]),
      .stall_in  (stall_v[P]),
      .select1   (sel1_v[i]),
      .select2   (sel2_v[i]),
      .enable    (en_v[i]),
      .valid_out (vout_v[i]),
      .stall_out (stall_v[i])
    );
  end

  fj_valid_join #(.N(NB)) u_join (
    .branch_invalid (vout_v),
    .join_invalid   (join_valid_n)
  );

  assign a_select1 = sel1_v[0];
  assign a_select2 = sel2_v[0];
  assign a_enable  = en_v[0];
  assign a_valid_n = vout_v[0];
  assign a_stall   = stall_v[0];
  assign b_select1 = sel1_v[1];
  assign b_select2 = sel2_v[1];
  assign b_enable  = en_v[1];
  assign b_valid_n = vout_v[1];
  assign b_stall   = stall_v[1];

  // R7: the two stages move through delay mode together.
  a_r7_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (a_select2 == b_select2) && (a_enable == b_enable));

  // R3: a stall from B alone forces A to capture.
  a_r3_partner_capture: assert property (@(posedge clk) disable iff (!rst_n)
    b_stall |-> a_enable && a_select1);

  // R8: no routing from the spare flop without a preceding error.
  a_r8_single_episode: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_error || b_error) |=> !a_select2);

  // R6: a valid joined word needs both branches valid.
  a_r6_join_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    !join_valid_n |-> !a_valid_n && !b_valid_n);
endmodule

// File: tb/fj_pair_ctrl_tb.sv
`timescale 1ns/1ps
module fj_pair_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_error = 1'b0, a_up_valid_n = 1'b1, b_error = 1'b0, b_up_valid_n = 1'b1;
  logic a_select1, a_select2, a_enable, a_valid_n, a_stall;
  logic b_select1, b_select2, b_enable, b_valid_n, b_stall;
  logic join_valid_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model state (its own record of the last edge).
  logic m_trig_q = 1'b0;
  logic m_upa_q = 1'b1;
  logic m_upb_q = 1'b1;

  always #2.5 clk = ~clk;

  fj_pair_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_error(a_error), .a_up_valid_n(a_up_valid_n),
    .b_error(b_error), .b_up_valid_n(b_up_valid_n),
    .a_select1(a_select1), .a_select2(a_select2), .a_enable(a_enable),
    .a_valid_n(a_valid_n), .a_stall(a_stall),
    .b_select1(b_select1), .b_select2(b_select2), .b_enable(b_enable),
    .b_valid_n(b_valid_n), .b_stall(b_stall),
    .join_valid_n(join_valid_n)
  );

  function automatic logic exp_invalid(logic any_err, logic up_q);
    if (any_err) return 1'b1;
    return up_q;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle's inputs at the falling edge, check, then advance the model.
  task automatic cycle(logic ea, logic eb, logic ua, logic ub);
    logic anyerr, ev_a, ev_b;
    @(negedge clk);
    a_error = ea; b_error = eb; a_up_valid_n = ua; b_up_valid_n = ub;
    #1;
    anyerr = ea | eb;
    ev_a = exp_invalid(anyerr, m_upa_q);
    ev_b = exp_invalid(anyerr, m_upb_q);
    chk("R2 a_stall", a_stall, ea);
    chk("R2 b_stall", b_stall, eb);
    chk("R3 a_select1", a_select1, anyerr);
    chk("R3 a_enable", a_enable, anyerr);
    chk("R3 b_select1", b_select1, anyerr);
    chk("R3 b_enable", b_enable, anyerr);
    chk("R4 a_select2", a_select2, m_trig_q);
    chk("R4 b_select2", b_select2, m_trig_q);
    chk("R5 a_valid_n", a_valid_n, ev_a);
    chk("R5 b_valid_n", b_valid_n, ev_b);
    chk("R6 join_valid_n", join_valid_n, ev_a | ev_b);
    chk("R7 lockstep", a_select2 ^ b_select2 ^ a_enable ^ b_enable, 1'b0);
    m_trig_q = anyerr;
    m_upa_q = ua;
    m_upb_q = ub;
  endtask

  // R9: single error with valid upstream gives join invalid for one cycle only.
  task automatic single_err_window(bit on_b);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      a_error = (!on_b && k == 1); b_error = (on_b && k == 1);
      a_up_valid_n = 1'b0; b_up_valid_n = 1'b0;
      #1;
      chk("R9 join window", join_valid_n, (k == 1));
      if (k == 2) begin
        chk("R7 a_select2 after single error", a_select2, 1'b1);
        chk("R7 b_select2 after single error", b_select2, 1'b1);
      end
    end
    m_trig_q = 1'b0; m_upa_q = 1'b0; m_upb_q = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0007));
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 a_select2 in reset", a_select2, 1'b0);
    chk("R1 b_select2 in reset", b_select2, 1'b0);
    chk("R1 a_valid_n in reset", a_valid_n, 1'b1);
    chk("R1 b_valid_n in reset", b_valid_n, 1'b1);
    chk("R1 join in reset", join_valid_n, 1'b1);
    rst_n = 1'b1;
    cycle(0, 0, 0, 0);   // R1: first cycle after reset still invalid
    cycle(0, 0, 0, 0);
    // directed: single error on A, then on B
    cycle(1, 0, 0, 0); cycle(0, 0, 0, 0); cycle(0, 0, 0, 0);
    cycle(0, 1, 0, 0); cycle(0, 0, 0, 0); cycle(0, 0, 0, 0);
    // R8: both errors in one cycle -> one episode
    cycle(1, 1, 0, 0); cycle(0, 0, 0, 0); cycle(0, 0, 0, 0);
    // back-to-back errors, then an upstream-invalid word on one side only
    cycle(1, 0, 0, 0); cycle(0, 1, 0, 0); cycle(0, 0, 1, 0); cycle(0, 0, 0, 0);
    cycle(0, 0, 0, 0);
    single_err_window(0);
    single_err_window(1);
    cycle(0, 0, 0, 0);
    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      cycle(($urandom % 8) == 0, ($urandom % 8) == 0,
            ($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule